// File: doc/BRIEF.md
# Programmable Row Delay and Subtract

This block delays a 24-bit sample stream by a programmable number of clock cycles. A single-port-style memory of 2^ADDR_W words acts as a row buffer. An internal counter supplies the address. On every cycle the block reads the word held at the current slot and replaces it with the incoming sample, so a word comes back out one restart period after it went in.

The user sets the delay length by pulsing the active-low `start_n` once per row. Each low sample restarts the counter at slot 0, and the fixed pipeline adds four cycles on top of the restart period. A mode input selects the output:
- plain delay, where the output is the stored word;
- subtract, where the output is the stored word minus the sample arriving in the same slot, in wrapping two's-complement arithmetic.

Applications include row buffers for vertical filters and frame or line differencing.

Top module: `row_delay_sub`

## Requirements
- R1: The memory address comes only from the internal counter. The counter advances by one per cycle after a restart, and each advancing slot is read and then written with the sample that arrives for it.
- R2: A cycle in which `start_n` is sampled low restarts the counter, so the sample taken on that same edge is stored in slot 0.
- R3: With `sub_mode`=0 and `start_n` pulsed low every P cycles (1 <= P <= 2^ADDR_W), `dout` equals the `din` sample taken P+4 rising edges earlier.
- R4: Once the counter reaches its last slot (2^ADDR_W-1), it holds there until the next restart, and memory writes stop after that slot is written. With `sub_mode`=0, `dout` then repeats the word stored in the last slot, whatever `din` carries.
- R5: With `sub_mode`=1, `dout` equals the delayed word minus the `din` sample taken four edges earlier. The result is truncated to DATA_W bits with wraparound and no saturation.
- R6: While `rst` is high, `dout` is zero, and the counter is parked at its last slot with writes disabled.
- R7: Within one slot the old word is read before the new word overwrites it, so a restart on every cycle (P=1) gives a delay of exactly five cycles.
- R8: `sub_mode` changes only while `start_n` is high. The mode applies to each sample as it travels with that sample through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| start_n | input | 1 | Active-low row restart, sampled on the rising edge |
| sub_mode | input | 1 | 0 = plain delay, 1 = delayed minus current |
| din | input | DATA_W | Input sample stream |
| dout | output | DATA_W | Registered output sample |

## Verification
The bench sweeps many restart periods with a 16-slot buffer, from one cycle up to the full depth, in both modes.
- An off-by-one in the pipeline would shift every sample by one cycle and break the P+4 relation.
- A write-before-read ordering would show up at P=1 as a delay of four instead of five.
- A counter that wraps instead of holding would make the output change after pulses stop, where it should freeze on the last slot's word.
- Sample values large enough to force borrows check that the subtraction wraps instead of clamping.

// File: rtl/row_delay_sub.sv
module row_delay_sub #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_n,
  input  logic              sub_mode,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic              s1_start_n, s1_mode, s2_mode, a_mode, s3_mode;
  logic [DATA_W-1:0] s1_din, s2_din, a_din, s3_din, rd_q;
  logic [ADDR_W-1:0] cnt, a_addr;
  logic              held, a_we;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s1_start_n <= 1'b1; s1_mode <= 1'b0; s1_din <= '0;
      cnt <= LAST; held <= 1'b1; s2_mode <= 1'b0; s2_din <= '0;
      a_addr <= LAST; a_we <= 1'b0; a_mode <= 1'b0; a_din <= '0;
      s3_mode <= 1'b0; s3_din <= '0; dout <= '0;
    end else begin
      s1_start_n <= start_n; s1_mode <= sub_mode; s1_din <= din;
      if (!s1_start_n) begin
        cnt  <= '0;
        held <= 1'b0;
      end else begin
        if (cnt != LAST) cnt <= cnt + 1'b1;
        held <= (cnt == LAST);
      end
      s2_mode <= s1_mode; s2_din <= s1_din;
      a_addr <= cnt; a_we <= !held; a_mode <= s2_mode; a_din <= s2_din;
      s3_mode <= a_mode; s3_din <= a_din;
      dout <= s3_mode ? (rd_q - s3_din) : rd_q;
    end
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[a_addr];
    if (a_we) mem[a_addr] <= a_din;
  end

  // R1: counter steps by one between restarts
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
    (s1_start_n && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

  // R2: a low start sample restarts at slot 0 with writes enabled
  assert_cnt_restart_R2: assert property (@(posedge clk) disable iff (rst)
    !s1_start_n |=> (cnt == '0 && !held));

  // R4: counter parks on the last slot and stays parked
  assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (s1_start_n && cnt == LAST) |=> (cnt == LAST && held));

  assert_held_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (held && s1_start_n) |=> held);

  // R8: mode may not move while start is active
  assert_mode_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !start_n |-> $stable(sub_mode));
endmodule

// File: tb/row_delay_sub_bench.sv
module row_delay_sub_bench;
  localparam int DW = 24;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_n = 1'b1;
  logic sub_mode = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;

  always #5 clk = ~clk;

  row_delay_sub #(.DATA_W(DW), .ADDR_W(AW)) u_row_delay_sub (
    .clk(clk), .rst(rst), .start_n(start_n), .sub_mode(sub_mode),
    .din(din), .dout(dout));

  int total = 0;
  int bad = 0;
  int k = 0;
  logic [DW-1:0] hist [4096];
  logic          hmode [4096];
  int cfg_start = 1 << 30;
  int per = 1;
  int hold_from = 1 << 30;

  function automatic logic [DW-1:0] gen(int idx);
    logic [31:0] v;
    v = idx * 32'h009E_3779 ^ (idx << 13) ^ 32'h00A5_5A00;
    return v[DW-1:0];
  endfunction

  task automatic check_edge(int m);
    int c;
    logic [DW-1:0] old, exp;
    string tag;
    c = m - 4;
    if (c < cfg_start + per) return;
    if (c >= hold_from) begin old = hist[hold_from - 1]; tag = "R4"; end
    else begin
      old = hist[c - per];
      if (per == 1) tag = "R7";
      else if (c < cfg_start + 2 * per) tag = "R2";
      else if (hmode[c]) tag = "R5";
      else tag = "R3";
    end
    exp = hmode[c] ? old - hist[c] : old;
    total++;
    if (dout !== exp) begin
      bad++;
      $display("FAIL %s edge=%0d P=%0d mode=%0d actual=%h expected=%h",
               tag, m, per, hmode[c], dout, exp);
    end
  endtask

  task automatic step(logic st, logic md);
    @(negedge clk);
    if (k > 0) check_edge(k - 1);
    din = gen(k); start_n = st; sub_mode = md;
    hist[k] = din; hmode[k] = md;
    k++;
  endtask

  task automatic run_cfg(int p, logic md, int pulse_rows, int tail);
    for (int i = 0; i < 6; i++) step(1'b1, md);
    per = p; cfg_start = k; hold_from = 1 << 30;
    for (int i = 0; i < pulse_rows * p; i++) step(!(i % p == 0), md);
    if (tail > 0) begin
      hold_from = cfg_start + (pulse_rows - 1) * p + DEPTH;
      for (int i = 0; i < tail; i++) step(1'b1, md);
    end
    for (int i = 0; i < 4; i++) step(1'b1, md);
    cfg_start = 1 << 30;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      total++;
      if (dout !== '0) begin
        bad++;
        $display("FAIL R6 reset actual=%h expected=%h", dout, {DW{1'b0}});
      end
    end
    rst = 1'b0;
    for (int md = 0; md < 2; md++) begin
      run_cfg(1, md[0], 12, 0);
      for (int p = 2; p <= DEPTH; p++) run_cfg(p, md[0], 3, 0);
    end
    run_cfg(DEPTH, 1'b0, 3, 30);
    run_cfg(DEPTH, 1'b1, 3, 30);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule